// File: doc/BRIEF.md
# Programmable Watchdog Timer with Shaped Reset Output

This block is a watchdog timer driven from a small byte-wide register port. Software sets three things: a start-up delay in seconds, a timeout count, and a control byte. The control byte picks the count unit (seconds or minutes), the output style (held level or a single pulse), the output polarity and the pulse width. Setting the enable bit starts a run. The block first waits out the start-up delay, then counts the timeout down. When the count runs out it raises a sticky status bit and drives the reset output.

A prescaler divides the system clock into a millisecond tick. Second and minute ticks are derived from that tick, so the delays, the timeout and the pulse widths all share one timebase. While the watchdog is enabled, software kicks it by rewriting the timeout register. A kick restarts the whole run, start-up delay included. The prescaler is cleared at each kick, at the end of the start-up delay and at expiry. Every interval is therefore an exact multiple of the tick.

Top module: `guard_timer`

## Requirements
- R1: After reset, all three registers read 0x00, the watchdog is disabled, and the output sits at its inactive level. With polarity 0 the inactive level is 1.
- R2: The register map is:
  - address 0: start-up delay in bits 6:0; bit 7 reads 0.
  - address 2: timeout count in bits 7:0.
  - address 1: control byte: bit 6 status, bit 5 enable, bit 4 pulse mode, bit 3 minute unit, bit 2 polarity, bits 1:0 pulse width.
  - Control bit 7 and address 3 always read 0. Writes to them change nothing.
- R3: Let E0 be the clock edge that sets the enable bit, or the edge that kicks the watchdog. Let T be the clocks per second, P the start-up delay and R the timeout count. With the second unit, the output asserts at edge E0 + T·P + T·R + 2 and no earlier.
- R4: With the minute unit (control bit 3 = 1), the timeout count uses units of 60·T clocks, or SEC_PER_MIN·T in general. The start-up delay stays in seconds.
- R5: The status bit sets on the expiry edge. Writing 1 to control bit 6 clears it. Writing 0 to it leaves it unchanged.
- R6: In level mode (bit 4 = 0) the output stays asserted after expiry. It releases when status is cleared or when enable is cleared.
- R7: In pulse mode (bit 4 = 1) the output asserts for exactly W ms and then releases. W is 1, 20 or 100 ms for width codes 00, 01 and 10, and 4 s for code 11.
- R8: Polarity bit 2 = 1 makes the asserted level 1. Polarity bit 2 = 0 makes the asserted level 0.
- R9: While enabled, a write to address 2 reloads both counts and restarts the run, start-up delay included. Timing is then measured from that write edge.
- R10: A start-up delay of 0 or a timeout count of 0 skips that stage. With both set to 0, the output asserts two edges after the enabling write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| wdt_out | output | 1 | Reset output, polarity set by control bit 2 |

## Verification
On every cycle, assertions check the following local properties. Expiry always lands in the done stage. The start-up counter never climbs without a kick. Status sets on expiry and survives a write of 0. A pulse only starts on an expiry and dies as soon as the watchdog is disabled. The end-to-end latencies can only be shown by the bench scenarios. These cover the sweep over delays, counts and units, the pulse widths under both polarities, the kick restart, and the release of the level output. In each case the bench measures the cycle counts at the pin and compares them with the arithmetic in R3, R4 and R7.

// File: rtl/gt_pkg.sv
// Package: register addresses, control bit positions and the run-stage
// encoding shared by the watchdog timer modules.
package gt_pkg;
    localparam logic [1:0] ADDR_DELAY = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_COUNT = 2'd2;

    localparam int B_STATUS = 6;
    localparam int B_ENABLE = 5;
    localparam int B_PULSE  = 4;
    localparam int B_MINUTE = 3;
    localparam int B_POL    = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_COUNT,
        ST_DONE
    } stage_t;
endpackage

// File: rtl/gt_tick_gen.sv
// Tick generator: divides the system clock into millisecond, second and
// minute strobes. Each strobe is one clock wide. A minute strobe coincides
// with a second strobe, which coincides with a millisecond strobe.
// Assumes every divider ratio is at least 2. 'restart' zeroes all stages
// so the next millisecond strobe arrives CLKS_PER_MS clocks later.
module gt_tick_gen #(
    parameter int CLKS_PER_MS = 50000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic ms_tick,
    output logic sec_tick,
    output logic min_tick
);
    localparam int CW = $clog2(CLKS_PER_MS);
    localparam int MW = $clog2(MS_PER_SEC);
    localparam int SW = $clog2(SEC_PER_MIN);

    logic [CW-1:0] clk_cnt;
    logic [MW-1:0] ms_cnt;
    logic [SW-1:0] sec_cnt;

    // Strobes decoded from the terminal count of each stage.
    always_comb begin
        ms_tick  = (clk_cnt == CW'(CLKS_PER_MS - 1));
        sec_tick = ms_tick && (ms_cnt == MW'(MS_PER_SEC - 1));
        min_tick = sec_tick && (sec_cnt == SW'(SEC_PER_MIN - 1));
    end

    // Cascaded wrap-around counters, cleared on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            clk_cnt <= '0;
            ms_cnt  <= '0;
            sec_cnt <= '0;
        end else begin
            clk_cnt <= ms_tick ? '0 : clk_cnt + CW'(1);
            if (ms_tick) ms_cnt <= sec_tick ? '0 : ms_cnt + MW'(1);
            if (sec_tick) sec_cnt <= min_tick ? '0 : sec_cnt + SW'(1);
        end
    end
endmodule

// File: rtl/gt_regs.sv
// Register file: holds the start-up delay, the timeout count and the
// control byte, and serves reads combinationally. It decodes kicks: an
// enabling write while disabled, or a count write while enabled. It passes
// the count value to be loaded on that same edge. Status is set by expiry
// (which wins over a clear) and cleared by writing 1 to it.
module gt_regs
    import gt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       expire_i,
    output logic [7:0] rdata,
    output logic [6:0] delay_o,
    output logic [7:0] load_count_o,
    output logic       en_o,
    output logic       pulse_o,
    output logic       minute_o,
    output logic       pol_o,
    output logic [1:0] width_o,
    output logic       status_o,
    output logic       kick_o
);
    logic [6:0] delay_q;
    logic [7:0] count_q;
    logic [4:0] cfg_q;      // pulse, minute, polarity, width[1:0]
    logic       en_q;
    logic       status_q;

    logic wr_delay, wr_ctrl, wr_count;

    // Address decode of the write strobe.
    always_comb begin
        wr_delay = wr_en && (addr == ADDR_DELAY);
        wr_ctrl  = wr_en && (addr == ADDR_CTRL);
        wr_count = wr_en && (addr == ADDR_COUNT);
    end

    // Kick detection and the count value that goes with it.
    always_comb begin
        kick_o       = (wr_ctrl && wdata[B_ENABLE] && !en_q) || (wr_count && en_q);
        load_count_o = wr_count ? wdata : count_q;
    end

    // Register storage with write-one-to-clear status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_q  <= '0;
            count_q  <= '0;
            cfg_q    <= '0;
            en_q     <= 1'b0;
            status_q <= 1'b0;
        end else begin
            if (wr_delay) delay_q <= wdata[6:0];
            if (wr_count) count_q <= wdata;
            if (wr_ctrl) begin
                cfg_q <= wdata[4:0];
                en_q  <= wdata[B_ENABLE];
            end
            if (expire_i)                         status_q <= 1'b1;
            else if (wr_ctrl && wdata[B_STATUS])  status_q <= 1'b0;
        end
    end

    // Read multiplexer; unused bits and addresses read as zero.
    always_comb begin
        case (addr)
            ADDR_DELAY: rdata = {1'b0, delay_q};
            ADDR_CTRL:  rdata = {1'b0, status_q, en_q, cfg_q};
            ADDR_COUNT: rdata = count_q;
            default:    rdata = 8'h00;
        endcase
    end

    assign delay_o  = delay_q;
    assign en_o     = en_q;
    assign pulse_o  = cfg_q[B_PULSE];
    assign minute_o = cfg_q[B_MINUTE];
    assign pol_o    = cfg_q[B_POL];
    assign width_o  = cfg_q[1:0];
    assign status_o = status_q;

    // R5: expiry always leaves the status bit set on the next cycle.
    assert_status_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> status_q);

    // R5: a control write with bit 6 low never clears status.
    assert_w1c_zero_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[B_STATUS] && status_q) |=> status_q);
endmodule

// File: rtl/gt_counter.sv
// Run sequencer: start-up delay stage (seconds), then timeout stage
// (seconds or minutes), then done. A kick loads both counts and enters the
// delay stage. Clearing enable returns to idle. A stage with a zero count
// ends on the cycle after entry. 'stage_done' and 'expire' are
// single-cycle strobes used to realign the tick generator.
module gt_counter
    import gt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       kick_i,
    input  logic [6:0] delay_i,
    input  logic [7:0] count_i,
    input  logic       minute_i,
    input  logic       sec_tick,
    input  logic       min_tick,
    output logic       stage_done,
    output logic       expire
);
    stage_t     st;
    logic [6:0] delay_left;
    logic [7:0] count_left;
    logic       unit_tick;

    // Stage-end strobes and the tick of the selected unit.
    always_comb begin
        unit_tick  = minute_i ? min_tick : sec_tick;
        stage_done = en_i && !kick_i && (st == ST_DELAY) && (delay_left == '0);
        expire     = en_i && !kick_i && (st == ST_COUNT) && (count_left == '0);
    end

    // Stage register and down-counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            delay_left <= '0;
            count_left <= '0;
        end else if (kick_i) begin
            st         <= ST_DELAY;
            delay_left <= delay_i;
            count_left <= count_i;
        end else if (!en_i) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_DELAY: begin
                    if (delay_left == '0) st <= ST_COUNT;
                    else if (sec_tick)    delay_left <= delay_left - 7'd1;
                end
                ST_COUNT: begin
                    if (count_left == '0) st <= ST_DONE;
                    else if (unit_tick)   count_left <= count_left - 8'd1;
                end
                default: st <= st;
            endcase
        end
    end

    // R3: an expiry is always followed by the done stage.
    assert_expire_to_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (st == ST_DONE));

    // R9: without a kick the delay counter never grows.
    assert_delay_no_grow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_DELAY) && !kick_i) |=> (delay_left <= $past(delay_left)));
endmodule

// File: rtl/gt_out_shaper.sv
// Output shaper: in level mode the asserted state follows the status bit
// while enabled. In pulse mode one expiry starts a pulse lasting the
// selected number of millisecond ticks. The tick generator is realigned on
// expiry, so the pulse is exactly that many milliseconds. Polarity is
// applied last.
module gt_out_shaper #(
    parameter int PW0_MS  = 1,
    parameter int PW1_MS  = 20,
    parameter int PW2_MS  = 100,
    parameter int PW3_SEC = 4,
    parameter int MS_PER_SEC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       expire_i,
    input  logic       pulse_i,
    input  logic       pol_i,
    input  logic [1:0] width_i,
    input  logic       status_i,
    input  logic       ms_tick,
    output logic       pin_o
);
    localparam int PW3_MS = PW3_SEC * MS_PER_SEC;
    localparam int PCW    = $clog2(PW0_MS + PW1_MS + PW2_MS + PW3_MS + 1);

    logic [PCW-1:0] pulse_left;
    logic [PCW-1:0] width_ms;
    logic           pulse_act;
    logic           active;

    // Width code to milliseconds.
    always_comb begin
        case (width_i)
            2'b00:   width_ms = PCW'(PW0_MS);
            2'b01:   width_ms = PCW'(PW1_MS);
            2'b10:   width_ms = PCW'(PW2_MS);
            default: width_ms = PCW'(PW3_MS);
        endcase
    end

    // Pulse timer: load on expiry, count down on millisecond ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_act  <= 1'b0;
            pulse_left <= '0;
        end else if (!en_i) begin
            pulse_act  <= 1'b0;
        end else if (expire_i && pulse_i) begin
            pulse_act  <= 1'b1;
            pulse_left <= width_ms;
        end else if (pulse_act && ms_tick) begin
            if (pulse_left <= PCW'(1)) pulse_act <= 1'b0;
            pulse_left <= pulse_left - PCW'(1);
        end
    end

    // Combine level and pulse sources, then apply polarity.
    always_comb begin
        active = pulse_act || (!pulse_i && status_i && en_i);
        pin_o  = pol_i ? active : !active;
    end

    // R7: a pulse only begins on an expiry.
    assert_pulse_from_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_act) |-> $past(expire_i));

    // R6: disabling the watchdog ends any pulse on the next cycle.
    assert_pulse_off_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pulse_act);
endmodule

// File: rtl/guard_timer.sv
// Top level: register port, tick generator, run sequencer and output
// shaper. The tick generator is realigned on a kick, at the end of the
// start-up delay and at expiry, so every interval is an exact multiple of
// its unit measured from that edge. Synchronous active-low reset.
module guard_timer #(
    parameter int CLKS_PER_MS = 50000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60,
    parameter int PW0_MS      = 1,
    parameter int PW1_MS      = 20,
    parameter int PW2_MS      = 100,
    parameter int PW3_SEC     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       wdt_out
);
    logic [6:0] delay_v;
    logic [7:0] load_count;
    logic       en, pulse_mode, minute, pol, status, kick;
    logic [1:0] width_sel;
    logic       ms_tick, sec_tick, min_tick;
    logic       stage_done, expire, restart;

    // Timebase realignment points.
    always_comb restart = kick || stage_done || expire;

    gt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .expire_i(expire), .rdata(rdata), .delay_o(delay_v),
        .load_count_o(load_count), .en_o(en), .pulse_o(pulse_mode),
        .minute_o(minute), .pol_o(pol), .width_o(width_sel),
        .status_o(status), .kick_o(kick)
    );

    gt_tick_gen #(
        .CLKS_PER_MS(CLKS_PER_MS), .MS_PER_SEC(MS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)
    ) u_ticks (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .ms_tick(ms_tick), .sec_tick(sec_tick), .min_tick(min_tick)
    );

    gt_counter u_count (
        .clk(clk), .rst_n(rst_n), .en_i(en), .kick_i(kick), .delay_i(delay_v),
        .count_i(load_count), .minute_i(minute), .sec_tick(sec_tick),
        .min_tick(min_tick), .stage_done(stage_done), .expire(expire)
    );

    gt_out_shaper #(
        .PW0_MS(PW0_MS), .PW1_MS(PW1_MS), .PW2_MS(PW2_MS), .PW3_SEC(PW3_SEC),
        .MS_PER_SEC(MS_PER_SEC)
    ) u_shape (
        .clk(clk), .rst_n(rst_n), .en_i(en), .expire_i(expire),
        .pulse_i(pulse_mode), .pol_i(pol), .width_i(width_sel),
        .status_i(status), .ms_tick(ms_tick), .pin_o(wdt_out)
    );

    // R6: while disabled for two cycles, the pin rests at its inactive level.
    assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(!en)) |-> (wdt_out == !pol));
endmodule

// File: tb/sim_guard_timer.sv
// Bench: small timebase (2 clocks/ms, 4 ms/s, 3 s/min), sweeps delays,
// counts, units, pulse widths and polarities, checking cycle counts.
module sim_guard_timer;
    localparam int C = 2, M = 4, S = 3;
    localparam int T = C * M;
    localparam int U_MIN = T * S;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       wdt_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    guard_timer #(
        .CLKS_PER_MS(C), .MS_PER_SEC(M), .SEC_PER_MIN(S),
        .PW0_MS(1), .PW1_MS(3), .PW2_MS(5), .PW3_SEC(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wdt_out(wdt_out)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wait_assert(input logic p, output int n);
        n = 0;
        while (wdt_out !== p && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_release(input logic p, output int n);
        n = 0;
        while (wdt_out === p && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, w, exp;
        int widths[4];
        widths[0] = 1; widths[1] = 3; widths[2] = 5; widths[3] = 2 * M;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(2'd0, v); check(v == 8'h00, "R1", v, 0);
        rd(2'd1, v); check(v == 8'h00, "R1", v, 0);
        rd(2'd2, v); check(v == 8'h00, "R1", v, 0);
        check(wdt_out == 1'b1, "R1", wdt_out, 1);

        // R2: register map and ignored bits
        wr(2'd0, 8'hFF); rd(2'd0, v); check(v == 8'h7F, "R2", v, 8'h7F);
        wr(2'd2, 8'hA5); rd(2'd2, v); check(v == 8'hA5, "R2", v, 8'hA5);
        wr(2'd1, 8'h9F); rd(2'd1, v); check(v == 8'h1F, "R2", v, 8'h1F);
        wr(2'd3, 8'hFF); rd(2'd3, v); check(v == 8'h00, "R2", v, 0);
        rd(2'd1, v); check(v == 8'h1F, "R2", v, 8'h1F);
        check(wdt_out == 1'b0, "R8", wdt_out, 0);
        wr(2'd1, 8'h00);

        // R3/R4/R10: latency sweep, level mode, low polarity
        for (int un = 0; un < 2; un++) begin
            for (int p = 0; p < 3; p++) begin
                for (int r = 0; r < 4; r++) begin
                    wr(2'd1, 8'h40);
                    wr(2'd0, 8'(p));
                    wr(2'd2, 8'(r));
                    wr(2'd1, 8'(8'h20 | (un << 3)));
                    exp = T * p + (un != 0 ? U_MIN : T) * r + 2;
                    wait_assert(1'b0, n);
                    if (p == 0 && r == 0) check(n == exp, "R10", n, exp);
                    else if (un != 0)    check(n == exp, "R4", n, exp);
                    else                 check(n == exp, "R3", n, exp);
                end
            end
        end

        // R7/R8: pulse widths under both polarities
        for (int pl = 0; pl < 2; pl++) begin
            for (int ws = 0; ws < 4; ws++) begin
                wr(2'd1, 8'h40);
                wr(2'd0, 8'd0);
                wr(2'd2, 8'd1);
                wr(2'd1, 8'(8'h30 | (pl << 2) | ws));
                check(wdt_out == logic'(pl == 0), "R8", wdt_out, pl == 0);
                wait_assert(logic'(pl), n);
                check(n == T + 2, "R8", n, T + 2);
                wait_release(logic'(pl), w);
                check(w == C * widths[ws], "R7", w, C * widths[ws]);
                repeat (5) @(negedge clk);
                check(wdt_out == logic'(pl == 0), "R7", wdt_out, pl == 0);
            end
        end

        // R5/R6: level hold, write-0 no effect, write-1 clears
        wr(2'd1, 8'h40);
        wr(2'd0, 8'd0);
        wr(2'd2, 8'd0);
        wr(2'd1, 8'h24);
        wait_assert(1'b1, n); check(n == 2, "R10", n, 2);
        repeat (20) @(negedge clk);
        check(wdt_out == 1'b1, "R6", wdt_out, 1);
        rd(2'd1, v); check(v == 8'h64, "R5", v, 8'h64);
        wr(2'd1, 8'h24);
        rd(2'd1, v); check(v == 8'h64, "R5", v, 8'h64);
        check(wdt_out == 1'b1, "R6", wdt_out, 1);
        wr(2'd1, 8'h64);
        check(wdt_out == 1'b0, "R6", wdt_out, 0);
        rd(2'd1, v); check(v == 8'h24, "R5", v, 8'h24);

        // R6: disabling releases a level output, status stays set
        wr(2'd1, 8'h40);
        wr(2'd1, 8'h24);
        wait_assert(1'b1, n); check(n == 2, "R6", n, 2);
        wr(2'd1, 8'h04);
        check(wdt_out == 1'b0, "R6", wdt_out, 0);
        rd(2'd1, v); check(v == 8'h44, "R5", v, 8'h44);

        // R9: count write while enabled restarts the whole run
        wr(2'd1, 8'h40);
        wr(2'd0, 8'd1);
        wr(2'd2, 8'd2);
        wr(2'd1, 8'h20);
        repeat (T + 10) @(negedge clk);
        check(wdt_out == 1'b1, "R9", wdt_out, 1);
        wr(2'd2, 8'd2);
        exp = T * 1 + T * 2 + 2;
        wait_assert(1'b0, n);
        check(n == exp, "R9", n, exp);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule